// File: doc/BRIEF.md
# Four-Phase Return-to-Zero Handshake Link

This block carries parallel data words from a local producer to a local consumer across a link. The link has no shared strobe timing. A source controller and a destination controller pace each word with two control wires, a request wire and an acknowledge wire. The source always opens the exchange. Both wires must fall back to low before the next word can start. Each word therefore passes through four phases: request high, acknowledge high, request low, acknowledge low.

On its local side, the source accepts words through a ready/valid port. The destination holds each captured word in an output register and offers it on a ready/valid port. Both controllers share one clock here. Each side still sees the other side's control wire only through a parameterised registered input, so no progress ever depends on a common edge. The link wires are brought out as outputs so they can be observed.

Top module: `hs4_link`

## Requirements
- R1: After reset is released, `link_req_o` and `link_ack_o` are low, `dst_valid_o` is low and `src_ready_o` is high.
- R2: The word on `link_data_o` is in place no later than the cycle in which `link_req_o` rises, and it does not change while `link_req_o` stays high.
- R3: `link_ack_o` rises only while `link_req_o` is high.
- R4: `link_req_o` falls only while `link_ack_o` is high.
- R5: `link_ack_o` falls only while `link_req_o` is low.
- R6: `link_req_o` never rises while `link_ack_o` is high.
- R7: Every word accepted at the producer port appears at the consumer port exactly once and in acceptance order. This holds with no loss or duplication under any stall pattern on either side.
- R8: While `dst_valid_o` is high and `dst_ready_i` is low, the next cycle keeps `dst_valid_o` high with `dst_data_o` unchanged. The destination does not acknowledge a new word until its output register is free.
- R9: `src_ready_o` is low whenever either link wire is high, so at most one word is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_valid_i | input | 1 | Producer offers a word |
| src_ready_o | output | 1 | Source can take a word this cycle |
| src_data_i | input | DW | Producer word |
| dst_valid_o | output | 1 | Consumer word available |
| dst_ready_i | input | 1 | Consumer takes the word |
| dst_data_o | output | DW | Consumer word |
| link_req_o | output | 1 | Request (data-valid) wire driven by the source |
| link_ack_o | output | 1 | Acknowledge (data-accepted) wire driven by the destination |
| link_data_o | output | DW | Shared data lines driven by the source |

## Verification
The hardest situation to reach is a request that is pending while the destination's output register is still full. In that state the link must sit in its first phase without acknowledging and without disturbing the held word. The stimulus reaches it in two ways. One phase holds consumer ready low for a long stretch while the producer keeps pushing words. Another phase randomises stalls on both sides, so that consumption and a new request land close together. A scoreboard queue confirms ordering and exactly-once delivery. A monitor on the link wires checks every edge against the phase order.

// File: rtl/hs4_link_pkg.sv
package hs4_link_pkg;
  typedef enum logic [1:0] {
    SRC_IDLE = 2'd0,
    SRC_REQ  = 2'd1,
    SRC_DROP = 2'd2
  } src_state_e;

  typedef enum logic {
    DST_IDLE = 1'b0,
    DST_ACK  = 1'b1
  } dst_state_e;
endpackage

// File: rtl/hs4_sync.sv
module hs4_sync #(
  parameter int STAGES = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  generate
    if (STAGES == 0) begin : g_pass
      assign q_o = d_i;
    end else begin : g_regs
      logic [STAGES-1:0] sr_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= '0;
        else if (STAGES == 1) sr_q <= d_i;
        else sr_q <= {sr_q[STAGES-2:0], d_i};
      end
      assign q_o = sr_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/hs4_src.sv
module hs4_src
  import hs4_link_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  input  logic [DW-1:0] in_data_i,
  input  logic          ack_seen_i,
  output logic          req_o,
  output logic [DW-1:0] data_o
);
  src_state_e   state_q, state_d;
  logic [DW-1:0] data_q;

  assign in_ready_o = (state_q == SRC_IDLE) && !ack_seen_i;
  assign req_o      = (state_q == SRC_REQ);
  assign data_o     = data_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SRC_IDLE: if (in_valid_i && in_ready_o) state_d = SRC_REQ;
      SRC_REQ:  if (ack_seen_i) state_d = SRC_DROP;
      SRC_DROP: if (!ack_seen_i) state_d = SRC_IDLE;
      default:  state_d = SRC_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SRC_IDLE;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      // word lands on the lines in the same edge that raises request
      if (state_q == SRC_IDLE && in_valid_i && in_ready_o) data_q <= in_data_i;
    end
  end
endmodule

// File: rtl/hs4_dst.sv
module hs4_dst
  import hs4_link_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_seen_i,
  input  logic [DW-1:0] link_data_i,
  output logic          ack_o,
  output logic          out_valid_o,
  input  logic          out_ready_i,
  output logic [DW-1:0] out_data_o
);
  dst_state_e    state_q;
  logic          out_valid_q;
  logic [DW-1:0] out_data_q;
  logic          take;

  // capture only when the output slot is free or draining this cycle
  assign take = (state_q == DST_IDLE) && req_seen_i && (!out_valid_q || out_ready_i);

  assign ack_o       = (state_q == DST_ACK);
  assign out_valid_o = out_valid_q;
  assign out_data_o  = out_data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= DST_IDLE;
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
    end else begin
      unique case (state_q)
        DST_IDLE: if (take) state_q <= DST_ACK;
        DST_ACK:  if (!req_seen_i) state_q <= DST_IDLE;
        default:  state_q <= DST_IDLE;
      endcase
      if (take) begin
        out_valid_q <= 1'b1;
        out_data_q  <= link_data_i;
      end else if (out_ready_i) begin
        out_valid_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hs4_link.sv
module hs4_link #(
  parameter int DW          = 16,
  parameter int SYNC_STAGES = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          src_valid_i,
  output logic          src_ready_o,
  input  logic [DW-1:0] src_data_i,
  output logic          dst_valid_o,
  input  logic          dst_ready_i,
  output logic [DW-1:0] dst_data_o,
  output logic          link_req_o,
  output logic          link_ack_o,
  output logic [DW-1:0] link_data_o
);
  logic          req, ack, req_seen, ack_seen;
  logic [DW-1:0] ldata;

  hs4_src #(.DW(DW)) u_src (
    .clk_i, .rst_ni,
    .in_valid_i(src_valid_i), .in_ready_o(src_ready_o), .in_data_i(src_data_i),
    .ack_seen_i(ack_seen), .req_o(req), .data_o(ldata)
  );

  hs4_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk_i, .rst_ni, .d_i(req), .q_o(req_seen)
  );

  hs4_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk_i, .rst_ni, .d_i(ack), .q_o(ack_seen)
  );

  hs4_dst #(.DW(DW)) u_dst (
    .clk_i, .rst_ni,
    .req_seen_i(req_seen), .link_data_i(ldata), .ack_o(ack),
    .out_valid_o(dst_valid_o), .out_ready_i(dst_ready_i), .out_data_o(dst_data_o)
  );

  assign link_req_o  = req;
  assign link_ack_o  = ack;
  assign link_data_o = ldata;
endmodule

// File: rtl/hs4_link_chk.sv
module hs4_link_chk #(
  parameter int DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          src_ready_o,
  input logic          dst_valid_o,
  input logic          dst_ready_i,
  input logic [DW-1:0] dst_data_o,
  input logic          link_req_o,
  input logic          link_ack_o,
  input logic [DW-1:0] link_data_o
);
  p_data_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_req_o && $past(link_req_o)) |-> $stable(link_data_o));

  p_ack_rise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(link_ack_o) |-> link_req_o);

  p_req_fall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(link_req_o) |-> link_ack_o);

  p_ack_fall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(link_ack_o) |-> !link_req_o);

  p_req_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(link_req_o) |-> !link_ack_o);

  p_out_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dst_valid_o && !dst_ready_i) |=> (dst_valid_o && $stable(dst_data_o)));

  p_one_inflight_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_req_o || link_ack_o) |-> !src_ready_o);
endmodule

bind hs4_link hs4_link_chk #(.DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .src_ready_o(src_ready_o),
  .dst_valid_o(dst_valid_o), .dst_ready_i(dst_ready_i), .dst_data_o(dst_data_o),
  .link_req_o(link_req_o), .link_ack_o(link_ack_o), .link_data_o(link_data_o)
);

// File: tb/hs4_link_tb.sv
module hs4_link_tb;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          src_valid = 1'b0;
  logic [DW-1:0] src_data = '0;
  logic          dst_ready = 1'b0;
  logic          src_ready, dst_valid, req, ack;
  logic [DW-1:0] dst_data, ldata;

  int checks = 0;
  int errors = 0;
  int mode   = 0;   // 0 always ready, 1 random stalls, 2 long stall
  int delivered = 0;
  bit done = 1'b0;
  logic [DW-1:0] exp_q[$];

  always #10 clk = ~clk;

  hs4_link #(.DW(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .src_valid_i(src_valid), .src_ready_o(src_ready), .src_data_i(src_data),
    .dst_valid_o(dst_valid), .dst_ready_i(dst_ready), .dst_data_o(dst_data),
    .link_req_o(req), .link_ack_o(ack), .link_data_o(ldata)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // driver: offer one word, push expected when accepted
  task automatic send(input logic [DW-1:0] w, input int pre);
    for (int i = 0; i < pre; i++) @(negedge clk);
    src_valid = 1'b1;
    src_data  = w;
    forever begin
      if (src_ready) begin
        exp_q.push_back(w);
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    src_valid = 1'b0;
    src_data  = ~w;
  endtask

  // monitor: consumer side scoreboard and link phase checks
  initial begin
    logic pv_req = 1'b0, pv_ack = 1'b0, pv_hold = 1'b0;
    logic [DW-1:0] pv_ld = '0, pv_dd = '0;
    int stall = 0;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (pv_hold) chk(dst_valid && dst_data == pv_dd, "R8", dst_data, pv_dd);
      if (req && pv_req) chk(ldata == pv_ld, "R2", ldata, pv_ld);
      if (ack && !pv_ack) chk(pv_req && req, "R3", req, 1);
      if (!req && pv_req) chk(pv_ack, "R4", pv_ack, 1);
      if (!ack && pv_ack) chk(!pv_req, "R5", pv_req, 0);
      if (req && !pv_req) chk(!pv_ack, "R6", pv_ack, 0);
      if (req || ack) chk(!src_ready, "R9", src_ready, 0);
      case (mode)
        0: dst_ready = 1'b1;
        1: dst_ready = ($urandom_range(0, 2) == 0);
        default: begin
          if (stall < 40) begin stall++; dst_ready = 1'b0; end
          else begin dst_ready = 1'b1; stall = 0; end
        end
      endcase
      if (dst_valid && dst_ready) begin
        if (exp_q.size() == 0) chk(1'b0, "R7", dst_data, 0);
        else begin
          logic [DW-1:0] e;
          e = exp_q.pop_front();
          chk(dst_data == e, "R7", dst_data, e);
        end
        delivered++;
      end
      pv_hold = dst_valid && !dst_ready;
      pv_dd = dst_data;
      pv_req = req; pv_ack = ack; pv_ld = ldata;
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", delivered, 60);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!req, "R1", req, 0);
    chk(!ack, "R1", ack, 0);
    chk(!dst_valid, "R1", dst_valid, 0);
    chk(src_ready, "R1", src_ready, 1);

    mode = 0;
    for (int i = 0; i < 20; i++) send(16'h1000 + 16'(i * 7), 0);
    mode = 1;
    for (int i = 0; i < 20; i++) send(16'(($urandom & 16'hffff) ^ 16'h5a00), $urandom_range(0, 6));
    mode = 2;
    for (int i = 0; i < 20; i++) send(16'hf000 | 16'(i), 0);

    while (delivered < 60) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R7", exp_q.size(), 0);
    chk(delivered == 60, "R7", delivered, 60);
    chk(!dst_valid, "R7", dst_valid, 0);
    chk(!req && !ack, "R5", {req, ack}, 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule